// File: doc/BRIEF.md
# Width-Prefix Opcode Decoder

This block sits between the opcode fetch path of an 8-bit-family processor and its main instruction decoder. Each opcode byte that is fetched is classified: a byte whose low nibble is all ones, other than the capability query byte `$0F`, is a width prefix. A prefix carries a register width code and an address width code in its high nibble. The block holds those codes until the next real instruction is fetched. It then presents them to the datapath for that one instruction.

When the instruction-complete strobe arrives, both codes fall back to the default of 8-bit registers and 16-bit addresses. At the 8-bit register width the datapath clears the upper register bytes. Fetching `$0F` raises a one-cycle load strobe. While that strobe is high, the datapath copies the fixed capability byte into the accumulator. The capability byte uses the same field layout as a prefix high nibble, with a thread count in its low nibble.

Top module: `wpfx_decode`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `reg_wc`=00, `addr_wc`=00, `pfx_active`=0 and `cap_load`=0. A prefix fetched before reset does not apply to the first instruction fetched after reset.
- R2: A fetched byte (`fetch_stb`=1) whose bits 3:0 are 1111, other than `$0F`, is a prefix. If `done_stb` is low in that cycle, the prefix leaves `reg_wc`, `addr_wc` and `pfx_active` unchanged.
- R3: The first non-prefix fetch after a prefix drives the prefix's widths in the next cycle. `reg_wc` takes prefix bits 7:6, `addr_wc` takes prefix bits 5:4, and `pfx_active` is 1.
- R4: A register width field of 11 is reserved and is presented as 00 (8-bit). Codes 00, 01 and 10 mean 8, 16 and 24 bits.
- R5: An address width field of 01 means 24-bit and 00 means 16-bit. Fields 10 and 11 are presented as 00.
- R6: A non-prefix fetch with no prefix pending drives `reg_wc`=00, `addr_wc`=00 and `pfx_active`=0 in the next cycle.
- R7: `done_stb` without a non-prefix fetch in the same cycle returns `reg_wc`, `addr_wc` and `pfx_active` to 00/00/0 in the next cycle. A non-prefix fetch in the same cycle takes precedence.
- R8: A prefix fetched while another prefix is pending replaces the pending widths. The two do not combine.
- R9: Fetching `$0F` sets `cap_load` to 1 for exactly the next cycle. `$0F` is not a prefix, and it uses any pending widths like any other instruction.
- R10: `cap_value` always equals {register code, address code, thread count} in bits 7:6, 5:4 and 3:0. With the default parameters this is `$90`.
- R11: A prefix applies to one instruction only. The second non-prefix fetch after it sees the defaults.
- R12: `op_byte` has no effect while `fetch_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_byte | input | 8 | Fetched opcode byte |
| fetch_stb | input | 1 | Opcode-fetch strobe, `op_byte` valid |
| done_stb | input | 1 | Current instruction completes |
| reg_wc | output | 2 | Register width code for the current instruction |
| addr_wc | output | 2 | Address width code for the current instruction |
| pfx_active | output | 1 | Current instruction was prefixed |
| cap_load | output | 1 | Load `cap_value` into the accumulator this cycle |
| cap_value | output | 8 | Fixed capability byte |

## Verification
A pending prefix that is lost or left stuck in the wrong state shows up at the next non-prefix fetch. One cycle later, `pfx_active` and the width codes differ from what the prefix history predicts. A stale active width is seen in the cycle after `done_stb`, when the codes fail to return to 00. Wrong field slicing or wrong handling of reserved codes shows up in `reg_wc` or `addr_wc` one cycle after the prefixed instruction is fetched. A cycle-by-cycle model compared on every clock catches each of these cases within two cycles of the stimulus that exposes it.

// File: rtl/wpfx_pkg.sv
package wpfx_pkg;
  localparam int OPW = 8;
  localparam int NIB = OPW / 2;

  typedef enum logic [1:0] {RW8 = 2'b00, RW16 = 2'b01, RW24 = 2'b10, RWRSV = 2'b11} reg_w_e;
  typedef enum logic [1:0] {AW16 = 2'b00, AW24 = 2'b01} addr_w_e;

  typedef struct packed {
    logic [1:0] rw;
    logic [1:0] aw;
  } widths_t;

  localparam widths_t WIDTH_DEFAULT = '{rw: RW8, aw: AW16};

  // Map the upper nibble of a prefix onto legal width codes.
  function automatic widths_t decode_hi(input logic [NIB-1:0] hi);
    widths_t w;
    w.rw = (hi[3:2] == RWRSV) ? RW8 : hi[3:2];
    w.aw = (hi[1:0] == AW24) ? AW24 : AW16;
    return w;
  endfunction
endpackage

// File: rtl/wpfx_classify.sv
module wpfx_classify
  import wpfx_pkg::*;
#(
  parameter logic [OPW-1:0] QUERY_OP = 8'h0F
) (
  input  logic [OPW-1:0] op,
  input  logic           fetch,
  output logic           is_pfx,
  output logic           is_instr,
  output logic           is_query,
  output widths_t        w
);
  logic nib_all_ones;

  always_comb begin
    nib_all_ones = &op[NIB-1:0];
    is_query     = fetch && (op == QUERY_OP);
    is_pfx       = fetch && nib_all_ones && (op != QUERY_OP);
    is_instr     = fetch && !is_pfx;
    w            = decode_hi(op[OPW-1:NIB]);
  end
endmodule

// File: rtl/wpfx_pending.sv
module wpfx_pending
  import wpfx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  logic    consume,
  input  widths_t w_in,
  output logic    pend_v,
  output widths_t pend_w
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_w <= WIDTH_DEFAULT;
    end else if (load) begin
      pend_v <= 1'b1;
      pend_w <= w_in;
    end else if (consume) begin
      pend_v <= 1'b0;
    end
  end

  // R8: a second prefix overwrites the first, never merges with it
  p_replace_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (pend_v && pend_w == $past(w_in)));
  // R11: an instruction fetch always empties the pending slot
  p_consume_r11: assert property (@(posedge clk) disable iff (rst)
    (consume && !load) |=> !pend_v);
endmodule

// File: rtl/wpfx_active.sv
module wpfx_active
  import wpfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       done,
  input  logic       query,
  input  logic       pend_v,
  input  widths_t    pend_w,
  output logic [1:0] rw,
  output logic [1:0] aw,
  output logic       act,
  output logic       cap_ld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rw     <= RW8;
      aw     <= AW16;
      act    <= 1'b0;
      cap_ld <= 1'b0;
    end else begin
      cap_ld <= query;
      if (start) begin
        rw  <= pend_v ? pend_w.rw : WIDTH_DEFAULT.rw;
        aw  <= pend_v ? pend_w.aw : WIDTH_DEFAULT.aw;
        act <= pend_v;
      end else if (done) begin
        rw  <= WIDTH_DEFAULT.rw;
        aw  <= WIDTH_DEFAULT.aw;
        act <= 1'b0;
      end
    end
  end

  // R4: the reserved register code never reaches the datapath
  p_no_rsvd_r4: assert property (@(posedge clk) disable iff (rst) rw != RWRSV);
  // R7: completion without a new fetch restores the defaults
  p_done_default_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (rw == RW8 && aw == AW16 && !act));
  // R6: an instruction without a pending prefix runs at default widths
  p_unpfx_default_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !pend_v) |=> (!act && rw == RW8 && aw == AW16));
endmodule

// File: rtl/wpfx_decode.sv
module wpfx_decode
  import wpfx_pkg::*;
#(
  parameter logic [OPW-1:0] QUERY_OP    = 8'h0F,
  parameter logic [1:0]     CAP_REG     = 2'b10,
  parameter logic [1:0]     CAP_ADDR    = 2'b01,
  parameter logic [NIB-1:0] CAP_THREADS = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_byte,
  input  logic           fetch_stb,
  input  logic           done_stb,
  output logic [1:0]     reg_wc,
  output logic [1:0]     addr_wc,
  output logic           pfx_active,
  output logic           cap_load,
  output logic [OPW-1:0] cap_value
);
  localparam logic [OPW-1:0] CAP_BYTE = {CAP_REG, CAP_ADDR, CAP_THREADS};

  logic    is_pfx, is_instr, is_query, pend_v;
  widths_t dec_w, pend_w;

  wpfx_classify #(.QUERY_OP(QUERY_OP)) u_cls (
    .op(op_byte), .fetch(fetch_stb), .is_pfx(is_pfx),
    .is_instr(is_instr), .is_query(is_query), .w(dec_w));

  wpfx_pending u_pend (
    .clk(clk), .rst(rst), .load(is_pfx), .consume(is_instr),
    .w_in(dec_w), .pend_v(pend_v), .pend_w(pend_w));

  wpfx_active u_act (
    .clk(clk), .rst(rst), .start(is_instr), .done(done_stb),
    .query(is_query), .pend_v(pend_v), .pend_w(pend_w),
    .rw(reg_wc), .aw(addr_wc), .act(pfx_active), .cap_ld(cap_load));

  assign cap_value = CAP_BYTE;

  // R9: the load strobe follows only a fetch of the query byte
  p_cap_src_r9: assert property (@(posedge clk) disable iff (rst)
    cap_load |-> ($past(fetch_stb) && $past(op_byte) == QUERY_OP));
  // R2: a prefix fetch alone leaves the presented widths untouched
  p_pfx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (is_pfx && !done_stb) |=> ($stable(reg_wc) && $stable(addr_wc) && $stable(pfx_active)));
  // R12: nothing moves without a strobe
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (!fetch_stb && !done_stb) |=> ($stable(reg_wc) && $stable(addr_wc) && !cap_load));
endmodule

// File: tb/sim_wpfx_decode.sv
module sim_wpfx_decode;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_byte = 8'h00;
  logic       fetch_stb = 1'b0;
  logic       done_stb = 1'b0;
  logic [1:0] reg_wc, addr_wc;
  logic       pfx_active, cap_load;
  logic [7:0] cap_value;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  int m_pv = 0, m_pr = 0, m_pa = 0, m_r = 0, m_a = 0, m_act = 0, m_cap = 0;

  always #5 clk = ~clk;

  wpfx_decode u0 (
    .clk(clk), .rst(rst), .op_byte(op_byte), .fetch_stb(fetch_stb),
    .done_stb(done_stb), .reg_wc(reg_wc), .addr_wc(addr_wc),
    .pfx_active(pfx_active), .cap_load(cap_load), .cap_value(cap_value));

  always @(posedge clk) begin
    int hi_r, hi_a;
    bit isp, ins;
    if (rst) begin
      m_pv = 0; m_pr = 0; m_pa = 0; m_r = 0; m_a = 0; m_act = 0; m_cap = 0;
    end else begin
      isp  = fetch_stb && (op_byte % 16 == 15) && (op_byte != 8'h0F);
      ins  = fetch_stb && !isp;
      m_cap = (fetch_stb && op_byte == 8'h0F) ? 1 : 0;
      hi_r = op_byte / 64;
      hi_a = (op_byte / 16) % 4;
      if (ins) begin
        m_r = m_pv ? m_pr : 0; m_a = m_pv ? m_pa : 0; m_act = m_pv; m_pv = 0;
      end else if (done_stb) begin
        m_r = 0; m_a = 0; m_act = 0;
      end
      if (isp) begin
        m_pv = 1; m_pr = (hi_r == 3) ? 0 : hi_r; m_pa = (hi_a == 1) ? 1 : 0;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cycles > 2) begin
      checks++;
      if (reg_wc != m_r[1:0] || addr_wc != m_a[1:0] || pfx_active != m_act[0]
          || cap_load != m_cap[0] || cap_value != 8'h90) begin
        errors++;
        $display("FAIL model R3/R7/R9/R10 cyc %0d: got r=%0d a=%0d act=%0d cl=%0d cv=%h exp r=%0d a=%0d act=%0d cl=%0d cv=90",
                 cycles, reg_wc, addr_wc, pfx_active, cap_load, cap_value, m_r, m_a, m_act, m_cap);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected under 100000", cycles);
      finish_run();
    end
  end

  task automatic step(input logic [7:0] op, input logic f, input logic d);
    @(negedge clk);
    op_byte = op; fetch_stb = f; done_stb = d;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input string tag, input int er, input int ea, input int eact, input int ecl);
    checks++;
    if (reg_wc != er[1:0] || addr_wc != ea[1:0] || pfx_active != eact[0] || cap_load != ecl[0]) begin
      errors++;
      $display("FAIL %s: got r=%0d a=%0d act=%0d cl=%0d exp r=%0d a=%0d act=%0d cl=%0d",
               tag, reg_wc, addr_wc, pfx_active, cap_load, er, ea, eact, ecl);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    expect_out("R1 in reset", 0, 0, 0, 0);
    step(8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    step(8'h00, 1'b0, 1'b0);
    expect_out("R1 after release", 0, 0, 0, 0);
    checks++;
    if (cap_value != 8'h90) begin
      errors++;
      $display("FAIL R10: got cap_value=%h exp 90", cap_value);
    end
    step(8'h9F, 1'b1, 1'b0);  expect_out("R2 prefix holds outputs", 0, 0, 0, 0);
    step(8'hA5, 1'b1, 1'b0);  expect_out("R3 prefixed widths", 2, 1, 1, 0);
    step(8'h00, 1'b0, 1'b1);  expect_out("R7 done restores", 0, 0, 0, 0);
    step(8'hA5, 1'b1, 1'b0);  expect_out("R6 unprefixed", 0, 0, 0, 0);
    step(8'h4F, 1'b1, 1'b0);  step(8'hEA, 1'b1, 1'b0);
    step(8'hEA, 1'b1, 1'b0);  expect_out("R11 one instruction only", 0, 0, 0, 0);
    step(8'hDF, 1'b1, 1'b0);  step(8'hEA, 1'b1, 1'b0);
    expect_out("R4 reserved reg code", 0, 1, 1, 0);
    step(8'h6F, 1'b1, 1'b0);  step(8'hEA, 1'b1, 1'b0);
    expect_out("R5 reserved addr code", 1, 0, 1, 0);
    step(8'h4F, 1'b1, 1'b0);  step(8'h8F, 1'b1, 1'b0);  step(8'hEA, 1'b1, 1'b0);
    expect_out("R8 prefix replaces", 2, 0, 1, 0);
    step(8'h00, 1'b0, 1'b1);
    step(8'h0F, 1'b1, 1'b0);  expect_out("R9 query strobe", 0, 0, 0, 1);
    step(8'h00, 1'b0, 1'b0);  expect_out("R9 strobe one cycle", 0, 0, 0, 0);
    step(8'h1F, 1'b1, 1'b0);  step(8'h0F, 1'b1, 1'b0);
    expect_out("R9 query uses prefix", 0, 1, 1, 1);
    step(8'h00, 1'b0, 1'b1);
    step(8'h4F, 1'b0, 1'b0);  step(8'hEA, 1'b1, 1'b0);
    expect_out("R12 no strobe ignored", 0, 0, 0, 0);
    step(8'h9F, 1'b1, 1'b0);  step(8'h9F, 1'b0, 1'b0);
    expect_out("R12 idle holds", 0, 0, 0, 0);
    rst = 1'b1; step(8'h00, 1'b0, 1'b0); rst = 1'b0;
    step(8'hEA, 1'b1, 1'b0);  expect_out("R1 pending cleared", 0, 0, 0, 0);
    step(8'h8F, 1'b1, 1'b0);  step(8'hB5, 1'b1, 1'b1);
    expect_out("R7 fetch beats done", 2, 0, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] o;
      o = 8'($urandom);
      if ($urandom % 3 == 0) o[3:0] = 4'hF;
      if ($urandom % 16 == 0) o = 8'h0F;
      step(o, 1'($urandom % 4 != 0), 1'($urandom % 3 == 0));
    end
    step(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule